// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between a host bus and a multi-bank NOR-style flash array. It watches the bus on every clock. It recognises command writes and follows the multi-write unlock protocol that guards program and erase. When a sequence completes it raises a level request toward the embedded program or erase engine. The request carries the target address and data for a program, or a sector bitmask for an erase. The request stays high until the engine answers with a done strobe. Requests that would touch a write-protected sector are refused with a one-cycle error pulse.

Each bank can be switched into a fast-program mode in which a program needs only two writes. A high-voltage condition is modelled by a digital `acc` flag. While it is set, every bank behaves as if it were in fast-program mode and sector protection is lifted. An identifier mode replaces array read data with identifier words. With chip-enable high, or during reset, the read drivers are off.

Addresses are word addresses. The top `BANK_W` bits select a bank and the top `SECT_W` bits select a sector. The low 11 bits are compared against the unlock addresses 0x555 and 0x2AA. Command codes are taken from `wdata[7:0]`.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A clock edge counts as a command write only when `ce_n`=0, `we_n`=0 and `oe_n`=1. Any other combination leaves the sequence state and bank flags unchanged.
- R2: The writes 0xAA@0x555, 0x55@0x2AA, 0xA0@0x555 and then data D at address A raise `pgm_req` on the edge that samples the fourth write, with `pgm_addr`=A and `pgm_data`=D. `pgm_req` stays high and stable until the edge that samples `op_done`=1, and is low after that edge.
- R3: The writes 0xAA@0x555, 0x55@0x2AA and 0x20@0x555, with bank bits b on the third write, put only bank b into fast-program mode.
- R4: In a bank in fast-program mode, 0xA0 at any address of that bank followed by a data write raises `pgm_req`. In a bank not in that mode, the same two writes raise nothing.
- R5: In a bank in fast-program mode, 0x90 followed by 0x00 takes the bank out of that mode.
- R6: The writes 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA and then 0x30 at a sector address open a collection window of `ERS_WIN` cycles. Each further 0x30 write adds its sector and restarts the window. `ers_req` rises `ERS_WIN` edges after the last 0x30 write, with bit s of `ers_mask` set for every sector s collected.
- R7: The erase setup of R6 closed by 0x10@0x555 requests an erase with all mask bits set.
- R8: A write that does not fit the expected sequence, or a write whose low byte is 0xF0 at any step (including the program data step and the collection window), returns the decoder to read-array with no request.
- R9: When `acc`=0, a program or erase whose target includes a sector with its `prot_mask` bit set raises no request. Instead `err_pulse` is high for exactly one cycle.
- R10: While `acc`=1, every bank accepts the two-write program of R4 and protection is ignored for program and erase.
- R11: When `acc` falls, any two-write program begun only because of `acc` is abandoned, and banks not in fast-program mode and protection both return to normal.
- R12: After 0xAA@0x555, 0x55@0x2AA, 0x90@0x555, reads return identifier words selected by `addr[1:0]`: 0 gives `MFR_CODE`, 1 gives `DEV_CODE`, 2 gives the protect bit of the addressed sector, 3 gives the fast-program flag of the addressed bank (in bit 0). A 0xF0 write returns to array reads.
- R13: `dq_oe` is 1 only when `rst_n`=1, `ce_n`=0, `oe_n`=0 and `we_n`=1, and is 0 otherwise (standby, reset) regardless of `oe_n`. In read-array mode `dq_o` equals `arr_rdata`.
- R14: While a request is outstanding, all writes are ignored, and `pgm_req` and `ers_req` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | DQ_W | Write data; command byte in bits 7:0 |
| dq_o | output | DQ_W | Read data (zero when not driven) |
| dq_oe | output | 1 | Read data output enable |
| arr_rdata | input | DQ_W | Data from the flash array |
| acc | input | 1 | High-voltage accelerate condition |
| prot_mask | input | 2**SECT_W | Per-sector write protection |
| pgm_req | output | 1 | Program request to the embedded engine |
| pgm_addr | output | ADDR_W | Program target address |
| pgm_data | output | DQ_W | Program data |
| ers_req | output | 1 | Erase request to the embedded engine |
| ers_mask | output | 2**SECT_W | Sectors to erase |
| op_done | input | 1 | Engine completion strobe |
| err_pulse | output | 1 | One-cycle protection refusal |

## Verification
The decoder is driven with complete and broken four-write program sequences. These separate a real command from one that has a non-write cycle inside it, a wrong unlock address, or an early 0xF0. Two-write programs are sent to banks with and without fast-program mode, and with `acc` set, cleared, and dropped part-way through a sequence. This shows whether the per-bank flags and the forced mode are kept apart. Erases are run as single-sector, three-sector with a restarted window, and whole-chip. Each is checked in the cycle before and the cycle of the expected request, against protected and unprotected targets. Identifier reads and standby reads complete the read side.

// File: rtl/fcd_pkg.sv
// Shared definitions for the flash command decoder.
// Holds the sequencer state encoding and the command and unlock constants.
package fcd_pkg;

    typedef enum logic [3:0] {
        ST_READ,   // read array, idle
        ST_UNL1,   // first unlock write seen
        ST_UNL2,   // second unlock write seen
        ST_PROG,   // waiting for program data
        ST_ESU0,   // erase setup seen, waiting for first unlock
        ST_ESU1,   // erase first unlock seen
        ST_ESU2,   // erase second unlock seen
        ST_ECOL,   // collecting sector erase writes
        ST_BXIT,   // fast-program exit, waiting for 0x00
        ST_IDRD,   // identifier read mode
        ST_BUSY    // request outstanding
    } seq_state_e;

    localparam logic [7:0] CMD_UNL_A = 8'hAA;
    localparam logic [7:0] CMD_UNL_B = 8'h55;
    localparam logic [7:0] CMD_FASTP = 8'h20;
    localparam logic [7:0] CMD_PGM   = 8'hA0;
    localparam logic [7:0] CMD_ESU   = 8'h80;
    localparam logic [7:0] CMD_IDM   = 8'h90;
    localparam logic [7:0] CMD_RST   = 8'hF0;
    localparam logic [7:0] CMD_SECT  = 8'h30;
    localparam logic [7:0] CMD_CHIP  = 8'h10;
    localparam logic [7:0] CMD_FXIT  = 8'h00;

    localparam logic [10:0] ADR_UNL_A = 11'h555;
    localparam logic [10:0] ADR_UNL_B = 11'h2AA;

endpackage

// File: rtl/fcd_bus_qual.sv
// Bus cycle qualifier.
// Decides, for each clock, whether the bus carries a command write and
// whether the read drivers may be enabled. Assumes the bus controls are
// already synchronous to clk. Reset and chip-enable both gate everything.
module fcd_bus_qual (
    input  logic rst_n,
    input  logic ce_n,
    input  logic we_n,
    input  logic oe_n,
    output logic wr_stb,
    output logic rd_drv
);

    // Write: chip selected, write strobe low, output enable released.
    always_comb wr_stb = rst_n & ~ce_n & ~we_n & oe_n;

    // Read: chip selected, output enable low, no write strobe.
    always_comb rd_drv = rst_n & ~ce_n & ~oe_n & we_n;

endmodule

// File: rtl/fcd_ers_window.sv
// Sector-erase collection window timer.
// Reloads to WIN on each accepted sector write (arm) and counts down while
// the sequencer is collecting (run). fire is high in the last cycle of the
// window. The sequencer must ignore fire in a cycle that also holds a write.
module fcd_ers_window #(
    parameter int WIN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic run,
    output logic fire
);

    localparam int CW = $clog2(WIN + 1);

    logic [CW-1:0] cnt_q;

    // Window counter: reload on arm, clear when idle, else count down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (arm) begin
            cnt_q <= CW'(WIN);
        end else if (!run) begin
            cnt_q <= '0;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    // Expiry indication for the final cycle of the window.
    always_comb fire = run && (cnt_q == CW'(1));

endmodule

// File: rtl/fcd_seq.sv
// Command sequencer.
// Walks the unlock protocol on qualified writes, keeps one fast-program flag
// per bank, collects erase sectors, screens requests against protection and
// holds a request until op_done. Assumes wr_stb is one per accepted write
// and that acc is synchronous to clk.
module fcd_seq
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DQ_W   = 16,
    parameter int BANK_W = 2,
    parameter int SECT_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_stb,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DQ_W-1:0]       wdata,
    input  logic                  acc,
    input  logic [2**SECT_W-1:0]  prot_mask,
    input  logic                  op_done,
    input  logic                  win_fire,
    output logic                  win_arm,
    output logic                  win_run,
    output logic                  id_mode,
    output logic [2**BANK_W-1:0]  fastp,
    output logic                  pgm_req,
    output logic [ADDR_W-1:0]     pgm_addr,
    output logic [DQ_W-1:0]       pgm_data,
    output logic                  ers_req,
    output logic [2**SECT_W-1:0]  ers_mask,
    output logic                  err_pulse
);

    localparam int NBANK = 2**BANK_W;
    localparam int NSECT = 2**SECT_W;

    seq_state_e         state_q;
    logic [NBANK-1:0]   fastp_q;
    logic               forced_q;
    logic [BANK_W-1:0]  xit_bank_q;
    logic [NSECT-1:0]   col_mask_q;
    logic               pgm_req_q;
    logic [ADDR_W-1:0]  pgm_addr_q;
    logic [DQ_W-1:0]    pgm_data_q;
    logic               ers_req_q;
    logic [NSECT-1:0]   ers_mask_q;
    logic               err_q;

    logic [7:0]         cmd;
    logic [10:0]        lo;
    logic [BANK_W-1:0]  wbank;
    logic [SECT_W-1:0]  wsect;
    logic [NSECT-1:0]   sect_hot;
    logic [NSECT-1:0]   prot_eff;
    logic               fast_eff;
    logic               is_a, is_b, is_rst;
    logic               chip_hit, col_fire, ers_go, ers_blocked;
    logic               prog_lost, pgm_go, pgm_blocked;
    logic [NSECT-1:0]   cand_mask;

    // Field extraction from the current bus write.
    always_comb begin
        cmd      = wdata[7:0];
        lo       = addr[10:0];
        wbank    = addr[ADDR_W-1 -: BANK_W];
        wsect    = addr[ADDR_W-1 -: SECT_W];
        sect_hot = NSECT'(1) << wsect;
        is_a     = (cmd == CMD_UNL_A) && (lo == ADR_UNL_A);
        is_b     = (cmd == CMD_UNL_B) && (lo == ADR_UNL_B);
        is_rst   = (cmd == CMD_RST);
    end

    // Effective protection and fast-program mode under the accelerate flag.
    always_comb begin
        prot_eff = prot_mask & {NSECT{~acc}};
        fast_eff = fastp_q[wbank] | acc;
    end

    // Request launch decisions and protection screening.
    always_comb begin
        chip_hit    = (state_q == ST_ESU2) && wr_stb && (cmd == CMD_CHIP) && (lo == ADR_UNL_A);
        col_fire    = (state_q == ST_ECOL) && !wr_stb && win_fire;
        cand_mask   = chip_hit ? '1 : col_mask_q;
        ers_go      = chip_hit || col_fire;
        ers_blocked = |(cand_mask & prot_eff);
        prog_lost   = forced_q && !acc;
        pgm_go      = (state_q == ST_PROG) && wr_stb && !prog_lost && !is_rst;
        pgm_blocked = prot_eff[wsect];
    end

    // Window control toward the erase timer.
    always_comb begin
        win_arm = ((state_q == ST_ESU2) || (state_q == ST_ECOL)) && wr_stb && (cmd == CMD_SECT);
        win_run = (state_q == ST_ECOL);
    end

    // Sequencer state, bank flags and request registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_READ;
            fastp_q    <= '0;
            forced_q   <= 1'b0;
            xit_bank_q <= '0;
            col_mask_q <= '0;
            pgm_req_q  <= 1'b0;
            pgm_addr_q <= '0;
            pgm_data_q <= '0;
            ers_req_q  <= 1'b0;
            ers_mask_q <= '0;
            err_q      <= 1'b0;
        end else begin
            err_q <= 1'b0;
            unique case (state_q)
                ST_READ: begin
                    if (wr_stb) begin
                        if (is_rst) begin
                            state_q <= ST_READ;
                        end else if (fast_eff && (cmd == CMD_PGM)) begin
                            state_q  <= ST_PROG;
                            forced_q <= ~fastp_q[wbank];
                        end else if (fastp_q[wbank] && (cmd == CMD_IDM)) begin
                            state_q    <= ST_BXIT;
                            xit_bank_q <= wbank;
                        end else if (is_a) begin
                            state_q <= ST_UNL1;
                        end
                    end
                end
                ST_UNL1: if (wr_stb) state_q <= is_b ? ST_UNL2 : ST_READ;
                ST_UNL2: begin
                    if (wr_stb) begin
                        state_q <= ST_READ;
                        if (lo == ADR_UNL_A) begin
                            case (cmd)
                                CMD_PGM: begin
                                    state_q  <= ST_PROG;
                                    forced_q <= 1'b0;
                                end
                                CMD_ESU:   state_q <= ST_ESU0;
                                CMD_IDM:   state_q <= ST_IDRD;
                                CMD_FASTP: fastp_q[wbank] <= 1'b1;
                                default:   state_q <= ST_READ;
                            endcase
                        end
                    end
                end
                ST_PROG: begin
                    if (prog_lost || (wr_stb && is_rst)) begin
                        state_q <= ST_READ;
                    end else if (pgm_go) begin
                        if (pgm_blocked) begin
                            err_q   <= 1'b1;
                            state_q <= ST_READ;
                        end else begin
                            pgm_req_q  <= 1'b1;
                            pgm_addr_q <= addr;
                            pgm_data_q <= wdata;
                            state_q    <= ST_BUSY;
                        end
                    end
                end
                ST_ESU0: if (wr_stb) state_q <= is_a ? ST_ESU1 : ST_READ;
                ST_ESU1: if (wr_stb) state_q <= is_b ? ST_ESU2 : ST_READ;
                ST_ESU2, ST_ECOL: begin
                    if (ers_go) begin
                        if (ers_blocked) begin
                            err_q   <= 1'b1;
                            state_q <= ST_READ;
                        end else begin
                            ers_req_q  <= 1'b1;
                            ers_mask_q <= cand_mask;
                            state_q    <= ST_BUSY;
                        end
                    end else if (wr_stb) begin
                        if (cmd == CMD_SECT) begin
                            col_mask_q <= (state_q == ST_ECOL) ? (col_mask_q | sect_hot) : sect_hot;
                            state_q    <= ST_ECOL;
                        end else begin
                            state_q <= ST_READ;
                        end
                    end
                end
                ST_BXIT: begin
                    if (wr_stb) begin
                        if (cmd == CMD_FXIT) fastp_q[xit_bank_q] <= 1'b0;
                        state_q <= ST_READ;
                    end
                end
                ST_IDRD: if (wr_stb && is_rst) state_q <= ST_READ;
                ST_BUSY: begin
                    if (op_done) begin
                        pgm_req_q <= 1'b0;
                        ers_req_q <= 1'b0;
                        state_q   <= ST_READ;
                    end
                end
                default: state_q <= ST_READ;
            endcase
        end
    end

    always_comb begin
        id_mode   = (state_q == ST_IDRD);
        fastp     = fastp_q;
        pgm_req   = pgm_req_q;
        pgm_addr  = pgm_addr_q;
        pgm_data  = pgm_data_q;
        ers_req   = ers_req_q;
        ers_mask  = ers_mask_q;
        err_pulse = err_q;
    end

    // R14
    one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pgm_req_q && ers_req_q));

    // R9
    err_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> !err_q);

    // R2
    pgm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pgm_req_q && !op_done) |=> (pgm_req_q && $stable(pgm_addr_q) && $stable(pgm_data_q)));

    // R1
    flag_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(fastp_q));

    // R6
    ers_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ers_req_q) |-> (ers_mask_q != '0));

endmodule

// File: rtl/fcd_rd_mux.sv
// Read data path.
// Chooses between array data and identifier words and gates the drivers.
// Assumes id_sel, sector and bank come straight from the read address so
// that read timing matches array reads (purely combinational).
module fcd_rd_mux #(
    parameter int          DQ_W     = 16,
    parameter int          BANK_W   = 2,
    parameter int          SECT_W   = 4,
    parameter logic [15:0] MFR_CODE = 16'h0001,
    parameter logic [15:0] DEV_CODE = 16'h227E
) (
    input  logic                 rd_drv,
    input  logic                 id_mode,
    input  logic [1:0]           id_sel,
    input  logic [SECT_W-1:0]    rsect,
    input  logic [BANK_W-1:0]    rbank,
    input  logic [2**SECT_W-1:0] prot_mask,
    input  logic [2**BANK_W-1:0] fastp,
    input  logic [DQ_W-1:0]      arr_rdata,
    output logic [DQ_W-1:0]      dq_o,
    output logic                 dq_oe
);

    logic [DQ_W-1:0] id_word;

    // Identifier register bank, indexed by the low address bits.
    always_comb begin
        unique case (id_sel)
            2'd0:    id_word = DQ_W'(MFR_CODE);
            2'd1:    id_word = DQ_W'(DEV_CODE);
            2'd2:    id_word = {{(DQ_W-1){1'b0}}, prot_mask[rsect]};
            default: id_word = {{(DQ_W-1){1'b0}}, fastp[rbank]};
        endcase
    end

    // Output select and driver gating.
    always_comb begin
        dq_oe = rd_drv;
        dq_o  = rd_drv ? (id_mode ? id_word : arr_rdata) : '0;
    end

endmodule

// File: rtl/flash_cmd_decoder.sv
// Flash command sequence decoder, top level.
// Qualifies bus cycles, runs the command sequencer with its erase window
// timer, and muxes read data. Assumes ADDR_W >= SECT_W + 11 so that sector
// bits never overlap the unlock address field, and SECT_W >= BANK_W.
module flash_cmd_decoder #(
    parameter int          ADDR_W   = 16,
    parameter int          DQ_W     = 16,
    parameter int          BANK_W   = 2,
    parameter int          SECT_W   = 4,
    parameter int          ERS_WIN  = 8,
    parameter logic [15:0] MFR_CODE = 16'h0001,
    parameter logic [15:0] DEV_CODE = 16'h227E
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ce_n,
    input  logic                 we_n,
    input  logic                 oe_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DQ_W-1:0]      wdata,
    output logic [DQ_W-1:0]      dq_o,
    output logic                 dq_oe,
    input  logic [DQ_W-1:0]      arr_rdata,
    input  logic                 acc,
    input  logic [2**SECT_W-1:0] prot_mask,
    output logic                 pgm_req,
    output logic [ADDR_W-1:0]    pgm_addr,
    output logic [DQ_W-1:0]      pgm_data,
    output logic                 ers_req,
    output logic [2**SECT_W-1:0] ers_mask,
    input  logic                 op_done,
    output logic                 err_pulse
);

    localparam int NBANK = 2**BANK_W;

    logic             wr_stb, rd_drv;
    logic             win_arm, win_run, win_fire;
    logic             id_mode;
    logic [NBANK-1:0] fastp;

    fcd_bus_qual u_qual (
        .rst_n  (rst_n),
        .ce_n   (ce_n),
        .we_n   (we_n),
        .oe_n   (oe_n),
        .wr_stb (wr_stb),
        .rd_drv (rd_drv)
    );

    fcd_ers_window #(.WIN(ERS_WIN)) u_win (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (win_arm),
        .run   (win_run),
        .fire  (win_fire)
    );

    fcd_seq #(
        .ADDR_W (ADDR_W),
        .DQ_W   (DQ_W),
        .BANK_W (BANK_W),
        .SECT_W (SECT_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (wr_stb),
        .addr      (addr),
        .wdata     (wdata),
        .acc       (acc),
        .prot_mask (prot_mask),
        .op_done   (op_done),
        .win_fire  (win_fire),
        .win_arm   (win_arm),
        .win_run   (win_run),
        .id_mode   (id_mode),
        .fastp     (fastp),
        .pgm_req   (pgm_req),
        .pgm_addr  (pgm_addr),
        .pgm_data  (pgm_data),
        .ers_req   (ers_req),
        .ers_mask  (ers_mask),
        .err_pulse (err_pulse)
    );

    fcd_rd_mux #(
        .DQ_W     (DQ_W),
        .BANK_W   (BANK_W),
        .SECT_W   (SECT_W),
        .MFR_CODE (MFR_CODE),
        .DEV_CODE (DEV_CODE)
    ) u_rd (
        .rd_drv    (rd_drv),
        .id_mode   (id_mode),
        .id_sel    (addr[1:0]),
        .rsect     (addr[ADDR_W-1 -: SECT_W]),
        .rbank     (addr[ADDR_W-1 -: BANK_W]),
        .prot_mask (prot_mask),
        .fastp     (fastp),
        .arr_rdata (arr_rdata),
        .dq_o      (dq_o),
        .dq_oe     (dq_oe)
    );

endmodule

// File: tb/test_flash_cmd_decoder.sv
module test_flash_cmd_decoder;

    localparam int WIN = 8;

    typedef struct packed {
        logic [3:0]  rid;
        logic        done;
        logic [2:0]  ctl;   // {ce_n, we_n, oe_n}
        logic [15:0] adr;
        logic [15:0] dat;
        logic        xreq;
        logic        xerr;
    } vec_t;

    localparam logic [2:0] CW = 3'b001;  // write cycle
    localparam logic [2:0] CI = 3'b111;  // idle
    localparam logic [2:0] CB = 3'b000;  // write strobe with oe_n low (not a write)
    localparam int NV = 28;

    localparam vec_t VEC [NV] = '{
        '{4'd2, 1'b0, CW, 16'h0555, 16'h00AA, 1'b0, 1'b0},
        '{4'd2, 1'b0, CW, 16'h02AA, 16'h0055, 1'b0, 1'b0},
        '{4'd2, 1'b0, CW, 16'h0555, 16'h00A0, 1'b0, 1'b0},
        '{4'd2, 1'b0, CW, 16'h3010, 16'hBEEF, 1'b1, 1'b0},
        '{4'd2, 1'b0, CI, 16'h0000, 16'h0000, 1'b1, 1'b0},
        '{4'd2, 1'b1, CI, 16'h0000, 16'h0000, 1'b0, 1'b0},
        '{4'd1, 1'b0, CW, 16'h0555, 16'h00AA, 1'b0, 1'b0},
        '{4'd1, 1'b0, CB, 16'h02AA, 16'h0055, 1'b0, 1'b0},
        '{4'd1, 1'b0, CW, 16'h0555, 16'h00A0, 1'b0, 1'b0},
        '{4'd1, 1'b0, CW, 16'h3012, 16'h1234, 1'b0, 1'b0},
        '{4'd8, 1'b0, CW, 16'h0555, 16'h00AA, 1'b0, 1'b0},
        '{4'd8, 1'b0, CW, 16'h02AB, 16'h0055, 1'b0, 1'b0},
        '{4'd8, 1'b0, CW, 16'h0555, 16'h00A0, 1'b0, 1'b0},
        '{4'd8, 1'b0, CW, 16'h3014, 16'h5555, 1'b0, 1'b0},
        '{4'd8, 1'b0, CW, 16'h0555, 16'h00AA, 1'b0, 1'b0},
        '{4'd8, 1'b0, CW, 16'h02AA, 16'h0055, 1'b0, 1'b0},
        '{4'd8, 1'b0, CW, 16'h0555, 16'h00F0, 1'b0, 1'b0},
        '{4'd8, 1'b0, CW, 16'h3016, 16'h6666, 1'b0, 1'b0},
        '{4'd2, 1'b0, CW, 16'h0555, 16'h00AA, 1'b0, 1'b0},
        '{4'd2, 1'b0, CW, 16'h02AA, 16'h0055, 1'b0, 1'b0},
        '{4'd2, 1'b0, CW, 16'h0555, 16'h00A0, 1'b0, 1'b0},
        '{4'd2, 1'b0, CW, 16'h4000, 16'hCAFE, 1'b1, 1'b0},
        '{4'd2, 1'b1, CI, 16'h0000, 16'h0000, 1'b0, 1'b0},
        '{4'd9, 1'b0, CW, 16'h0555, 16'h00AA, 1'b0, 1'b0},
        '{4'd9, 1'b0, CW, 16'h02AA, 16'h0055, 1'b0, 1'b0},
        '{4'd9, 1'b0, CW, 16'h0555, 16'h00A0, 1'b0, 1'b0},
        '{4'd9, 1'b0, CW, 16'h5000, 16'hDEAD, 1'b0, 1'b1},
        '{4'd9, 1'b0, CI, 16'h0000, 16'h0000, 1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n, ce_n, we_n, oe_n, acc, op_done;
    logic [15:0] addr, wdata, arr_rdata, prot_mask;
    logic [15:0] dq_o, pgm_addr, pgm_data, ers_mask;
    logic        dq_oe, pgm_req, ers_req, err_pulse;

    int n_chk  = 0;
    int n_fail = 0;
    logic [15:0] rv;

    always #4 clk = ~clk;

    flash_cmd_decoder i_flash_cmd_decoder (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (ce_n),
        .we_n      (we_n),
        .oe_n      (oe_n),
        .addr      (addr),
        .wdata     (wdata),
        .dq_o      (dq_o),
        .dq_oe     (dq_oe),
        .arr_rdata (arr_rdata),
        .acc       (acc),
        .prot_mask (prot_mask),
        .pgm_req   (pgm_req),
        .pgm_addr  (pgm_addr),
        .pgm_data  (pgm_data),
        .ers_req   (ers_req),
        .ers_mask  (ers_mask),
        .op_done   (op_done),
        .err_pulse (err_pulse)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic bus_idle();
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    endtask

    // One write cycle; called and returning at a falling edge.
    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        bus_idle();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic rd(input logic [15:0] a, output logic [15:0] v);
        ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; addr = a;
        #1;
        v = dq_o;
        bus_idle();
    endtask

    task automatic done_pulse();
        op_done = 1'b1;
        @(negedge clk);
        op_done = 1'b0;
    endtask

    task automatic unlock(input logic [15:0] bank_base, input logic [7:0] c);
        wr(bank_base | 16'h0555, 16'h00AA);
        wr(bank_base | 16'h02AA, 16'h0055);
        wr(bank_base | 16'h0555, {8'h00, c});
    endtask

    task automatic erase_setup();
        unlock(16'h0000, 8'h80);
        wr(16'h0555, 16'h00AA);
        wr(16'h02AA, 16'h0055);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog act=running exp=finished");
        report();
        $finish;
    end

    initial begin
        rst_n = 1'b0; ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0;
        addr = '0; wdata = '0; acc = 1'b0; op_done = 1'b0;
        arr_rdata = 16'h1234; prot_mask = 16'h0020;
        repeat (3) @(negedge clk);
        // R13: drivers off while in reset even with a read pattern
        chk("R13 reset hiz", {31'b0, dq_oe}, 32'd0);
        chk("R2 reset pgm_req", {31'b0, pgm_req}, 32'd0);
        chk("R6 reset ers_req", {31'b0, ers_req}, 32'd0);
        chk("R9 reset err", {31'b0, err_pulse}, 32'd0);
        rst_n = 1'b1;
        bus_idle();
        @(negedge clk);

        // Table walk: R1 R2 R8 R9
        for (int v = 0; v < NV; v++) begin
            {ce_n, we_n, oe_n} = VEC[v].ctl;
            addr    = VEC[v].adr;
            wdata   = VEC[v].dat;
            op_done = VEC[v].done;
            @(negedge clk);
            bus_idle();
            op_done = 1'b0;
            n_chk++;
            if ({pgm_req, err_pulse} !== {VEC[v].xreq, VEC[v].xerr}) begin
                n_fail++;
                $display("FAIL R%0d vector %0d act=%b%b exp=%b%b", VEC[v].rid, v,
                         pgm_req, err_pulse, VEC[v].xreq, VEC[v].xerr);
            end
        end

        // R13: array read and standby
        rd(16'h0010, rv);
        chk("R13 array read data", {16'b0, rv}, 32'h1234);
        ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; #1;
        chk("R13 read drive on", {31'b0, dq_oe}, 32'd1);
        ce_n = 1'b1; #1;
        chk("R13 standby hiz", {31'b0, dq_oe}, 32'd0);
        bus_idle();
        @(negedge clk);

        // R12: identifier mode
        unlock(16'h0000, 8'h90);
        rd(16'h0000, rv); chk("R12 mfr code", {16'b0, rv}, 32'h0001);
        rd(16'h0001, rv); chk("R12 dev code", {16'b0, rv}, 32'h227E);
        rd(16'h5002, rv); chk("R12 prot bit set", {16'b0, rv}, 32'h0001);
        rd(16'h3002, rv); chk("R12 prot bit clear", {16'b0, rv}, 32'h0000);
        @(negedge clk);
        wr(16'h0000, 16'h00F0);
        rd(16'h0001, rv); chk("R12 back to array", {16'b0, rv}, 32'h1234);
        @(negedge clk);

        // R3: fast-program entry for bank 1 only
        unlock(16'h4000, 8'h20);
        unlock(16'h0000, 8'h90);
        rd(16'h4003, rv); chk("R3 bank1 flag set", {16'b0, rv}, 32'h0001);
        rd(16'h0003, rv); chk("R3 bank0 flag clear", {16'b0, rv}, 32'h0000);
        @(negedge clk);
        wr(16'h0000, 16'h00F0);

        // R4: two-write program in bank 1; ignored in bank 0
        wr(16'h4000, 16'h00A0);
        wr(16'h4100, 16'h1111);
        chk("R4 fast program req", {31'b0, pgm_req}, 32'd1);
        chk("R4 fast program addr", {16'b0, pgm_addr}, 32'h4100);
        chk("R4 fast program data", {16'b0, pgm_data}, 32'h1111);
        // R14: writes during busy are ignored
        unlock(16'h8000, 8'h20);
        chk("R14 req held busy", {31'b0, pgm_req}, 32'd1);
        chk("R14 addr held busy", {16'b0, pgm_addr}, 32'h4100);
        done_pulse();
        chk("R2 req drops after done", {31'b0, pgm_req}, 32'd0);
        unlock(16'h0000, 8'h90);
        rd(16'h8003, rv); chk("R14 bank2 flag untouched", {16'b0, rv}, 32'h0000);
        @(negedge clk);
        wr(16'h0000, 16'h00F0);
        wr(16'h0000, 16'h00A0);
        wr(16'h0100, 16'h2222);
        chk("R4 non-fast bank ignored", {31'b0, pgm_req}, 32'd0);

        // R5: leave fast-program mode in bank 1
        wr(16'h4000, 16'h0090);
        wr(16'h4000, 16'h0000);
        wr(16'h4000, 16'h00A0);
        wr(16'h4100, 16'h3333);
        chk("R5 fast mode left", {31'b0, pgm_req}, 32'd0);
        unlock(16'h0000, 8'h90);
        rd(16'h4003, rv); chk("R5 bank1 flag clear", {16'b0, rv}, 32'h0000);
        @(negedge clk);
        wr(16'h0000, 16'h00F0);

        // R6: single sector erase, window timing
        erase_setup();
        wr(16'h7000, 16'h0030);
        idle(WIN - 1);
        chk("R6 single before window", {31'b0, ers_req}, 32'd0);
        idle(1);
        chk("R6 single at window", {31'b0, ers_req}, 32'd1);
        chk("R6 single mask", {16'b0, ers_mask}, 32'h0080);
        done_pulse();

        // R6: three sectors with window restart
        erase_setup();
        wr(16'h7000, 16'h0030);
        idle(3);
        wr(16'h9000, 16'h0030);
        wr(16'hA000, 16'h0030);
        idle(WIN - 1);
        chk("R6 multi before window", {31'b0, ers_req}, 32'd0);
        idle(1);
        chk("R6 multi at window", {31'b0, ers_req}, 32'd1);
        chk("R6 multi mask", {16'b0, ers_mask}, 32'h0680);
        done_pulse();

        // R8: reset write inside the collection window
        erase_setup();
        wr(16'h7000, 16'h0030);
        wr(16'h0000, 16'h00F0);
        idle(WIN + 2);
        chk("R8 abort collection", {31'b0, ers_req}, 32'd0);

        // R9 R7: chip erase blocked by protection
        erase_setup();
        wr(16'h0555, 16'h0010);
        chk("R9 chip erase refused err", {31'b0, err_pulse}, 32'd1);
        chk("R9 chip erase no req", {31'b0, ers_req}, 32'd0);
        idle(1);
        chk("R9 err one cycle", {31'b0, err_pulse}, 32'd0);

        // R7: chip erase with no protection
        prot_mask = 16'h0000;
        erase_setup();
        wr(16'h0555, 16'h0010);
        chk("R7 chip erase req", {31'b0, ers_req}, 32'd1);
        chk("R7 chip erase mask", {16'b0, ers_mask}, 32'hFFFF);
        done_pulse();
        prot_mask = 16'h0020;

        // R10: accelerate forces fast mode and lifts protection
        acc = 1'b1;
        wr(16'h0000, 16'h00A0);
        wr(16'h5000, 16'h4444);
        chk("R10 forced program req", {31'b0, pgm_req}, 32'd1);
        chk("R10 protected sector accepted", {16'b0, pgm_addr}, 32'h5000);
        done_pulse();
        erase_setup();
        wr(16'h0555, 16'h0010);
        chk("R10 chip erase with acc", {16'b0, ers_mask}, 32'hFFFF);
        done_pulse();

        // R11: accelerate dropped mid-sequence
        wr(16'h0000, 16'h00A0);
        acc = 1'b0;
        idle(1);
        wr(16'h0100, 16'h7777);
        chk("R11 forced sequence abandoned", {31'b0, pgm_req}, 32'd0);
        wr(16'h0000, 16'h00A0);
        wr(16'h0100, 16'h7777);
        chk("R11 forced mode cleared", {31'b0, pgm_req}, 32'd0);
        unlock(16'h0000, 8'hA0);
        wr(16'h5000, 16'h8888);
        chk("R11 protection restored", {31'b0, err_pulse}, 32'd1);
        chk("R11 no req on protected", {31'b0, pgm_req}, 32'd0);

        idle(2);
        report();
        $finish;
    end

endmodule